// File: doc/BRIEF.md
# Cache Line Fill Bus Interface

This unit sits between a cache controller and a single-master memory bus of the cycle/strobe/acknowledge kind. The controller hands it one read request at a time. A request is either a four-word line fill or a single uncached word fetch. The unit drives the bus cycle, strobe and address. It captures each acknowledged data word and passes it back with a valid pulse and the word's index within the line. A one-clock done pulse marks the end of every request.

The parameter `FAST_BEATS` selects the beat timing. With the value 0 (registered timing) the strobe drops for one clock after every acknowledged beat, so each beat costs two clocks. A single fetch then ends with one clock in which the cycle signal is low. With the value 1 (fast timing) the strobe stays high across the beats of a line, so a zero-wait memory accepts one beat per clock.

The request side is a valid/ready handshake: a request is taken on a clock where both `req_valid` and `req_ready` are high. `req_ready` is high only while the unit is idle, and holding `req_valid` while the unit is busy has no effect. The response side has no back-pressure. A consumer must take `rsp_data` on every clock where `rsp_valid` is high.

Top module: `line_fill_biu`

## Requirements
- R1: A request is accepted only on a clock where `req_valid` and `req_ready` are both high; `req_ready` is high exactly while the unit is idle, and request inputs presented while busy do not change the addresses or data of the request in progress.
- R2: A line fill issues four beats. The first address is `req_addr` with bits [3:0] cleared, each acknowledged beat advances the address by 4, and the responses carry `rsp_idx` 0, 1, 2, 3 in that order.
- R3: A single fetch issues exactly one beat at `req_addr` with bits [1:0] cleared, and its response carries `rsp_idx` equal to `req_addr[3:2]`.
- R4: A clock with the strobe high and no acknowledge keeps the strobe high and the address unchanged, produces no response, and delays every later event of the request by one clock.
- R5: The data word on `wb_dat_i` at an acknowledged beat appears on `rsp_data` with `rsp_valid` high for exactly one clock, on the clock after the acknowledge.
- R6: `fill_done` is high for one clock, on the same clock as the last response of the request.
- R7: Registered timing, line fill with a zero-wait slave: the strobe is never high on the clock after an acknowledge, the cycle signal is high for 8 clocks, `fill_done` comes on the 8th clock after acceptance and `req_ready` returns on the 9th.
- R8: Registered timing, single fetch with a zero-wait slave: the cycle signal is high for 2 clocks, low on the 3rd while the unit is still busy, `fill_done` comes on the 2nd clock and `req_ready` returns on the 4th.
- R9: Fast timing, line fill with a zero-wait slave: the strobe is high on 4 consecutive clocks, and `fill_done` and `req_ready` both come on the 5th clock after acceptance.
- R10: Fast timing, single fetch with a zero-wait slave: one strobe clock, with `fill_done` and `req_ready` on the 2nd clock.
- R11: The strobe is never high without the cycle signal, and during a line fill the cycle signal stays high from the first beat until the last beat's data has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle; request taken when both are high |
| req_addr | input | ADDR_W | Byte address of the request |
| req_single | input | 1 | 1: single uncached word, 0: four-word line fill |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus beat strobe |
| wb_adr_o | output | ADDR_W | Beat byte address |
| wb_dat_i | input | DATA_W | Read data from the bus |
| wb_ack_i | input | 1 | Beat acknowledge |
| rsp_valid | output | 1 | Returned word valid, one clock per beat |
| rsp_data | output | DATA_W | Returned word |
| rsp_idx | output | 2 | Word index within the line |
| fill_done | output | 1 | Request complete pulse |

## Verification
A wrong sequencer state shows on the bus within one clock. It appears as a strobe where the registered timing needs a gap, a missing gap, or the cycle signal dropping early. It also shifts the clock on which `fill_done` or `req_ready` appears, and the bench checks that clock exactly for both timings, with and without stalls. A wrong address or index register appears on the next strobe as an address off the expected line offset. It appears one clock after the acknowledge as a wrong `rsp_idx` or a data word that does not match the address the bench's memory model was given.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BEAT,
    ST_GAP,
    ST_TAIL,
    ST_TURN
  } lfb_state_e;
endpackage

// File: rtl/lfb_seq.sv
module lfb_seq
  import lfb_pkg::*;
#(
  parameter int FAST = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic single_i,
  input  logic ack_i,
  input  logic last_i,
  output logic single_o,
  output logic cyc_o,
  output logic stb_o,
  output logic idle_o,
  output logic adv_o
);
  lfb_state_e state_q, state_d;
  logic       single_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_BEAT;
      ST_BEAT: begin
        if (ack_i) begin
          if (last_i) state_d = (FAST != 0) ? ST_IDLE : ST_TAIL;
          else        state_d = (FAST != 0) ? ST_BEAT : ST_GAP;
        end
      end
      ST_GAP:  state_d = ST_BEAT;
      ST_TAIL: state_d = single_q ? ST_TURN : ST_IDLE;
      ST_TURN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      single_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_i && state_q == ST_IDLE) single_q <= single_i;
    end
  end

  assign single_o = single_q;
  assign stb_o    = (state_q == ST_BEAT);
  assign cyc_o    = (state_q == ST_BEAT) || (state_q == ST_GAP) || (state_q == ST_TAIL);
  assign idle_o   = (state_q == ST_IDLE);
  assign adv_o    = stb_o && ack_i;

  // R11
  stb_implies_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> cyc_o);

  generate
    if (FAST == 0) begin : g_reg_timing
      // R7
      gap_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && ack_i) |=> !stb_o);
    end else begin : g_fast_timing
      // R9
      back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && ack_i && !last_i) |=> stb_o);
    end
  endgenerate
endmodule

// File: rtl/lfb_addr_gen.sv
module lfb_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 4,
  parameter int BYTES  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic                       load_single_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic                       adv_i,
  input  logic                       single_i,
  output logic [ADDR_W-1:0]          adr_o,
  output logic [$clog2(WORDS)-1:0]   idx_o,
  output logic                       last_o
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int OFF_W = $clog2(BYTES);
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(BYTES - 1);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'(WORDS * BYTES - 1);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(WORDS - 1);

  logic [ADDR_W-1:0] adr_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      adr_q <= addr_i & (load_single_i ? WORD_MASK : LINE_MASK);
      idx_q <= load_single_i ? addr_i[OFF_W +: IDX_W] : '0;
    end else if (adv_i) begin
      adr_q <= adr_q + ADDR_W'(BYTES);
      idx_q <= idx_q + 1'b1;
    end
  end

  assign adr_o  = adr_q;
  assign idx_o  = idx_q;
  assign last_o = single_i || (idx_q == IDX_LAST);
endmodule

// File: rtl/lfb_rsp_reg.sv
module lfb_rsp_reg #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              done_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
      idx_o   <= '0;
    end else begin
      valid_o <= cap_i;
      done_o  <= cap_i && last_i;
      if (cap_i) begin
        data_o <= data_i;
        idx_o  <= idx_i;
      end
    end
  end
endmodule

// File: rtl/line_fill_biu.sv
module line_fill_biu #(
  parameter int FAST_BEATS = 0,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WORDS      = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_single,
  output logic                     wb_cyc_o,
  output logic                     wb_stb_o,
  output logic [ADDR_W-1:0]        wb_adr_o,
  input  logic [DATA_W-1:0]        wb_dat_i,
  input  logic                     wb_ack_i,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  output logic [$clog2(WORDS)-1:0] rsp_idx,
  output logic                     fill_done
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int BYTES = DATA_W / 8;

  logic             start, idle, adv, last, single_q;
  logic [IDX_W-1:0] idx;

  assign req_ready = idle;
  assign start     = req_valid && idle;

  lfb_seq #(.FAST(FAST_BEATS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .single_i (req_single),
    .ack_i    (wb_ack_i),
    .last_i   (last),
    .single_o (single_q),
    .cyc_o    (wb_cyc_o),
    .stb_o    (wb_stb_o),
    .idle_o   (idle),
    .adv_o    (adv)
  );

  lfb_addr_gen #(.ADDR_W(ADDR_W), .WORDS(WORDS), .BYTES(BYTES)) u_addr (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (start),
    .load_single_i (req_single),
    .addr_i        (req_addr),
    .adv_i         (adv),
    .single_i      (single_q),
    .adr_o         (wb_adr_o),
    .idx_o         (idx),
    .last_o        (last)
  );

  lfb_rsp_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_i   (adv),
    .last_i  (last),
    .data_i  (wb_dat_i),
    .idx_i   (idx),
    .valid_o (rsp_valid),
    .data_o  (rsp_data),
    .idx_o   (rsp_idx),
    .done_o  (fill_done)
  );

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_stb_o && !wb_ack_i) |=> (wb_stb_o && $stable(wb_adr_o)));
  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!wb_cyc_o && !wb_stb_o));
  // R5
  rsp_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(wb_stb_o && wb_ack_i));
  // R6
  done_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> rsp_valid);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_done);
endmodule

// File: tb/line_fill_biu_bench.sv
module line_fill_biu_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic        rv_r = 1'b0, rv_f = 1'b0;
  logic [31:0] q_addr = '0;
  logic        q_single = 1'b0;
  logic        ack_en = 1'b1;
  logic        sel_fast = 1'b0;

  logic        rdy_r, cyc_r, stb_r, rspv_r, done_r;
  logic        rdy_f, cyc_f, stb_f, rspv_f, done_f;
  logic [31:0] adr_r, adr_f, rd_r, rd_f;
  logic [1:0]  idx_r, idx_f;
  logic        ack_r, ack_f;

  function automatic logic [31:0] mem(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, a[31:16] + 16'h0101};
  endfunction

  assign ack_r = stb_r && ack_en;
  assign ack_f = stb_f && ack_en;

  line_fill_biu #(.FAST_BEATS(0)) u_line_fill_biu (
    .clk(clk), .rst_n(rst_n), .req_valid(rv_r), .req_ready(rdy_r),
    .req_addr(q_addr), .req_single(q_single), .wb_cyc_o(cyc_r),
    .wb_stb_o(stb_r), .wb_adr_o(adr_r), .wb_dat_i(mem(adr_r)),
    .wb_ack_i(ack_r), .rsp_valid(rspv_r), .rsp_data(rd_r),
    .rsp_idx(idx_r), .fill_done(done_r));

  line_fill_biu #(.FAST_BEATS(1)) u_line_fill_biu_fast (
    .clk(clk), .rst_n(rst_n), .req_valid(rv_f), .req_ready(rdy_f),
    .req_addr(q_addr), .req_single(q_single), .wb_cyc_o(cyc_f),
    .wb_stb_o(stb_f), .wb_adr_o(adr_f), .wb_dat_i(mem(adr_f)),
    .wb_ack_i(ack_f), .rsp_valid(rspv_f), .rsp_data(rd_f),
    .rsp_idx(idx_f), .fill_done(done_f));

  logic        s_rdy, s_cyc, s_stb, s_rspv, s_done;
  logic [31:0] s_adr, s_rd;
  logic [1:0]  s_idx;
  assign s_rdy  = sel_fast ? rdy_f  : rdy_r;
  assign s_cyc  = sel_fast ? cyc_f  : cyc_r;
  assign s_stb  = sel_fast ? stb_f  : stb_r;
  assign s_rspv = sel_fast ? rspv_f : rspv_r;
  assign s_done = sel_fast ? done_f : done_r;
  assign s_adr  = sel_fast ? adr_f  : adr_r;
  assign s_rd   = sel_fast ? rd_f   : rd_r;
  assign s_idx  = sel_fast ? idx_f  : idx_r;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_rv(input bit v);
    if (sel_fast) rv_f = v; else rv_r = v;
  endtask

  // One request on the selected unit; checks addresses, data, indices and timing.
  task automatic txn(input bit fast, input bit single, input logic [31:0] addr,
                     input int stall_beat, input int stall_n, input bit noisy,
                     input string tag);
    int nbeats = single ? 1 : 4;
    logic [31:0] base = single ? {addr[31:2], 2'b00} : {addr[31:4], 4'h0};
    logic [1:0]  idx0 = single ? addr[3:2] : 2'd0;
    int exp_done, exp_ready, exp_cyc;
    int beats = 0, rsps = 0, stalls_left = stall_n;
    int done_cyc = 0, ready_cyc = 0, cyc_cnt = 0, stb_cnt = 0;
    bit cyc3 = 1'b0;
    if (!fast) begin
      exp_done  = single ? 2 : 8;
      exp_ready = single ? 4 : 9;
      exp_cyc   = single ? 2 : 8;
    end else begin
      exp_done  = single ? 2 : 5;
      exp_ready = single ? 2 : 5;
      exp_cyc   = single ? 1 : 4;
    end
    sel_fast = fast;
    @(negedge clk);
    chk(s_rdy == 1'b1, {"R1 ready before ", tag}, 32'(s_rdy), 1);
    q_addr = addr; q_single = single; ack_en = 1'b1;
    set_rv(1'b1);
    for (int n = 1; n < 200; n++) begin
      @(negedge clk);
      if (n == 1) begin
        if (noisy) begin q_addr = ~addr; q_single = ~single; end
        else set_rv(1'b0);
      end
      if (s_cyc) cyc_cnt++;
      if (n == 3) cyc3 = s_cyc;
      if (s_rspv) begin
        // R2 R3 R5
        chk(s_idx == 2'(idx0 + rsps), {"R2/R3 index ", tag}, 32'(s_idx), 32'(2'(idx0 + rsps)));
        chk(s_rd == mem(base + 32'(4 * rsps)), {"R5 data ", tag}, s_rd, mem(base + 32'(4 * rsps)));
        rsps++;
      end
      if (s_done) begin
        done_cyc = n;
        chk(s_rspv && rsps == nbeats, {"R6 done with last rsp ", tag}, 32'(rsps), 32'(nbeats));
      end
      if (s_stb) begin
        stb_cnt++;
        // R2 R3 R4: address of current beat, held during stalls
        chk(s_adr == base + 32'(4 * beats), {"R2/R4 address ", tag}, s_adr, base + 32'(4 * beats));
        chk(s_cyc, {"R11 cyc with stb ", tag}, 32'(s_cyc), 1);
        if (beats == stall_beat && stalls_left > 0) begin
          ack_en = 1'b0; stalls_left--;
        end else begin
          ack_en = 1'b1; beats++;
        end
      end else ack_en = 1'b1;
      if (s_rdy) begin
        ready_cyc = n;
        set_rv(1'b0);
        break;
      end
    end
    ack_en = 1'b1;
    chk(beats == nbeats, {"R2/R3 beat count ", tag}, 32'(beats), 32'(nbeats));
    chk(rsps == nbeats, {"R5 response count ", tag}, 32'(rsps), 32'(nbeats));
    chk(stb_cnt == nbeats + stall_n, {"R4 strobe clocks ", tag}, 32'(stb_cnt), 32'(nbeats + stall_n));
    chk(done_cyc == exp_done + stall_n, {"R7/R8/R9/R10 done clock ", tag},
        32'(done_cyc), 32'(exp_done + stall_n));
    chk(ready_cyc == exp_ready + stall_n, {"R1/R7/R8/R9/R10 ready clock ", tag},
        32'(ready_cyc), 32'(exp_ready + stall_n));
    chk(cyc_cnt == exp_cyc + stall_n, {"R11 cyc clocks ", tag}, 32'(cyc_cnt), 32'(exp_cyc + stall_n));
    if (!fast && single && stall_n == 0)
      chk(cyc3 == 1'b0, {"R8 idle cyc on third clock ", tag}, 32'(cyc3), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!cyc_r && !stb_r && rdy_r && !rspv_r && !done_r, "R1 reset state reg", 32'(cyc_r), 0);
    chk(!cyc_f && !stb_f && rdy_f && !rspv_f && !done_f, "R1 reset state fast", 32'(cyc_f), 0);
  endtask

  task automatic t_reg_line;   txn(1'b0, 1'b0, 32'h0000_1238, 9, 0, 1'b0, "R7 reg line");      endtask
  task automatic t_reg_single; txn(1'b0, 1'b1, 32'h0000_4A5B, 9, 0, 1'b0, "R8 reg single");    endtask
  task automatic t_fast_line;  txn(1'b1, 1'b0, 32'hC0DE_0074, 9, 0, 1'b0, "R9 fast line");     endtask
  task automatic t_fast_single;txn(1'b1, 1'b1, 32'h8000_0006, 9, 0, 1'b0, "R10 fast single");  endtask
  task automatic t_reg_stall;  txn(1'b0, 1'b0, 32'h0000_2000, 2, 3, 1'b0, "R4 reg stall");     endtask
  task automatic t_fast_stall; txn(1'b1, 1'b0, 32'hFFFF_FFF0, 0, 2, 1'b0, "R4 fast stall");    endtask
  task automatic t_fast_stall_single; txn(1'b1, 1'b1, 32'h0000_0104, 0, 1, 1'b0, "R4 fast single stall"); endtask
  task automatic t_reg_noisy;  txn(1'b0, 1'b0, 32'h1357_9BDC, 1, 1, 1'b1, "R1 reg busy req");  endtask
  task automatic t_fast_noisy; txn(1'b1, 1'b1, 32'h2468_ACEC, 9, 0, 1'b1, "R1 fast busy req"); endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reg_line();
    t_reg_single();
    t_fast_line();
    t_fast_single();
    t_reg_stall();
    t_fast_stall();
    t_fast_stall_single();
    t_reg_noisy();
    t_fast_noisy();
    t_reg_line();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule